// File: doc/BRIEF.md
# Grouped GPIO External Interrupt Controller

This block watches up to fifteen groups of general-purpose input lines, with up to sixteen lines in each group, and turns their activity into interrupt requests. Every line passes through a two-flop synchroniser. Each set of four neighbouring lines shares a trigger selector, which chooses low level, high level, falling edge, rising edge or both edges. A detected event latches a pending bit. Software enables or blocks each line with a mask bit and clears pending bits by writing ones.

The pending state is kept whether or not a line is masked. Every pending and unmasked line drives a single combined interrupt output. A read-only service word names one such line as a packed group/pin code, so a handler can dispatch it without scanning the pending words. Two groups share each 32-bit configuration, mask and pending word. All registers sit behind a simple single-cycle register bus with a combinational read port.

Top module: `eint_ctrl`

## Requirements
- R1: A new input value that is first captured by clock edge k sets its pending bit at edge k+2, and not earlier.
- R2: Trigger selector codes are 4 bits wide: 0 means low level, 1 means high level, 2 means falling edge, 4 means rising edge and 6 means both edges. Any other code never sets a pending bit.
- R3: Four adjacent word bits share one selector. The selector for word bit n is held in configuration bits [4*floor(n/4)+3 : 4*floor(n/4)].
- R4: Group g (1-based) lives in word floor((g-1)/2) at bit ((g-1) mod 2)*16 + pin. The address is 6 bits: bits [5:4] choose the space (0 configuration, 1 mask, 2 pending, 3 service) and bits [3:0] choose the word. A word index past the last word reads as 0 and ignores writes. Bits with no line behind them read as 0.
- R5: A mask bit at 1 keeps its line out of the interrupt output and the service code. A mask bit at 0 lets the line through. Pending bits still latch while masked.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A detection in the same cycle as the clear wins.
- R7: While a level trigger's level holds, the pending bit stays set, and it comes back on the edge after any clear.
- R8: The service word holds the group (1..N) in bits [7:4] and the pin in bits [3:0], with all higher bits 0. When nothing is pending and unmasked, the word is 0. The lowest group wins, then the lowest pin.
- R9: The interrupt output is high exactly when some pending bit has a mask bit of 0. It follows the registers in the same cycle.
- R10: After reset, every selector is rising edge (configuration words 0x44444444), every mask bit is 1, every pending bit is 0 and the interrupt output is low.
- R11: Configuration and mask words read back exactly as written. Writes to the service space have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | NGRP*GL | Input lines; line g*GL+p is pin p of 0-based group g |
| bus_we | input | 1 | Write strobe, applied on the clock edge |
| bus_addr | input | AW | Register address: space in the top two bits, word index below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong pending or mask bit shows up on irq and in the service code in the same cycle it is written. A corrupted selector or synchroniser stage shows up as a pending bit that appears one cycle early or late, or never appears, two edges after the input change. A priority error appears as a wrong group or pin code as soon as two unmasked lines are pending together. The bench compares irq and the addressed read word against its reference model on every clock, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int SEL_W  = 4;

  typedef enum logic [3:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trig_e;

  typedef enum logic [1:0] {
    SPACE_CFG  = 2'd0,
    SPACE_MASK = 2'd1,
    SPACE_PEND = 2'd2,
    SPACE_SVC  = 2'd3
  } space_e;

  // Decide whether one line fires under a selector; unknown codes never fire.
  function automatic logic line_hit(input logic [SEL_W-1:0] sel,
                                    input logic cur, input logic old);
    logic r;
    case (trig_e'(sel))
      TRIG_LOW:  r = ~cur;
      TRIG_HIGH: r = cur;
      TRIG_FALL: r = old & ~cur;
      TRIG_RISE: r = ~old & cur;
      TRIG_BOTH: r = old ^ cur;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl   = s2_q;
  assign lvl_d = s3_q;
endmodule

// File: rtl/eint_word.sv
module eint_word
  import eint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg,
  input  logic [WORD_W-1:0] valid,
  input  logic [WORD_W-1:0] lvl,
  input  logic [WORD_W-1:0] lvl_d,
  input  logic [WORD_W-1:0] clr,
  output logic [WORD_W-1:0] pend
);
  logic [WORD_W-1:0] hit, pend_d, pend_q;

  for (genvar i = 0; i < WORD_W; i++) begin : g_line
    localparam int SB = (i / SEL_W) * SEL_W;
    assign hit[i] = valid[i] & line_hit(cfg[SB +: SEL_W], lvl[i], lvl_d[i]);
  end

  always_comb begin
    pend_d = (pend_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/eint_svc.sv
module eint_svc #(
  parameter int NGRP = 9,
  parameter int GL   = 16,
  parameter int GW   = 4,
  parameter int PW   = 4
) (
  input  logic [NGRP*GL-1:0] eff,
  output logic [GW+PW-1:0]   code
);
  always_comb begin
    logic found;
    found = 1'b0;
    code  = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int p = 0; p < GL; p++) begin
        if (!found && eff[g*GL+p]) begin
          found = 1'b1;
          code  = {GW'(g + 1), PW'(p)};
        end
      end
    end
  end
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int NGRP = 9,
  parameter int GL   = 16,
  parameter int AW   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*GL-1:0]   ext_in,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 irq
);
  // GL must not exceed 16 and NGRP must not exceed 15 (4-bit codes).
  localparam int NLINE = NGRP * GL;
  localparam int NWORD = (NGRP + 1) / 2;
  localparam int IDX_W = AW - 2;
  localparam logic [WORD_W-1:0] CFG_RST = {(WORD_W/SEL_W){4'(TRIG_RISE)}};

  space_e             space;
  logic [IDX_W-1:0]   idx;
  logic [NLINE-1:0]   lvl, lvl_d, eff;
  logic [7:0]         svc_code;

  logic [WORD_W-1:0]  cfg_q   [NWORD];
  logic [WORD_W-1:0]  mask_q  [NWORD];
  logic [WORD_W-1:0]  pend_w  [NWORD];
  logic [WORD_W-1:0]  clr_w   [NWORD];
  logic [WORD_W-1:0]  lvl_w   [NWORD];
  logic [WORD_W-1:0]  old_w   [NWORD];
  logic [WORD_W-1:0]  valid_w [NWORD];
  logic [NWORD-1:0]   cfg_en, mask_en;

  assign space = space_e'(bus_addr[AW-1 -: 2]);
  assign idx   = bus_addr[IDX_W-1:0];

  eint_sync #(.W(NLINE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in), .lvl(lvl), .lvl_d(lvl_d)
  );

  // Write decode: clock enables and clear strobes.
  always_comb begin
    for (int w = 0; w < NWORD; w++) begin
      cfg_en[w]  = bus_we && (space == SPACE_CFG)  && (idx == IDX_W'(w));
      mask_en[w] = bus_we && (space == SPACE_MASK) && (idx == IDX_W'(w));
      clr_w[w]   = (bus_we && (space == SPACE_PEND) && (idx == IDX_W'(w)))
                   ? bus_wdata : '0;
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[w]  <= CFG_RST;
        mask_q[w] <= '1;
      end else begin
        if (cfg_en[w])  cfg_q[w]  <= bus_wdata;
        if (mask_en[w]) mask_q[w] <= bus_wdata;
      end
    end

    // Two groups per word: lower half, upper half.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int K = 2 * w + b / HALF_W;
      localparam int P = b % HALF_W;
      if (P < GL && K < NGRP) begin : g_on
        assign lvl_w[w][b]   = lvl[K*GL+P];
        assign old_w[w][b]   = lvl_d[K*GL+P];
        assign valid_w[w][b] = 1'b1;
        assign eff[K*GL+P]   = pend_w[w][b] & ~mask_q[w][b];
      end else begin : g_off
        assign lvl_w[w][b]   = 1'b0;
        assign old_w[w][b]   = 1'b0;
        assign valid_w[w][b] = 1'b0;
      end
    end

    eint_word u_word (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[w]), .valid(valid_w[w]),
      .lvl(lvl_w[w]), .lvl_d(old_w[w]), .clr(clr_w[w]), .pend(pend_w[w])
    );
  end

  eint_svc #(.NGRP(NGRP), .GL(GL), .GW(4), .PW(4)) u_svc (
    .eff(eff), .code(svc_code)
  );

  assign irq = |eff;

  always_comb begin
    bus_rdata = '0;
    if (space == SPACE_SVC) begin
      bus_rdata = {{(WORD_W-8){1'b0}}, svc_code};
    end else begin
      for (int w = 0; w < NWORD; w++) begin
        if (idx == IDX_W'(w)) begin
          case (space)
            SPACE_CFG:  bus_rdata = cfg_q[w];
            SPACE_MASK: bus_rdata = mask_q[w];
            default:    bus_rdata = pend_w[w];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk #(
  parameter int NGRP = 9,
  parameter int AW   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          irq
);
  localparam int NWORD = (NGRP + 1) / 2;
  localparam logic [AW-3:0] NW_IX = (AW-2)'(NWORD);
  localparam logic [3:0]    TOP_G = 4'(NGRP);

  logic [1:0]    sp;
  logic [AW-3:0] ix;
  assign sp = bus_addr[AW-1 -: 2];
  assign ix = bus_addr[AW-3:0];

  // R8
  svc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == 2'd3 && irq) |-> (bus_rdata[7:4] != 4'd0 && bus_rdata[31:8] == 24'd0));

  // R8
  svc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == 2'd3 && !irq) |-> (bus_rdata == 32'd0));

  // R8
  svc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == 2'd3) |-> (bus_rdata[7:4] <= TOP_G));

  // R11
  mask_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_we) && $past(sp) == 2'd1 && $past(ix) < NW_IX
     && $stable(bus_addr)) |-> (bus_rdata == $past(bus_wdata)));

  // R11
  cfg_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_we) && $past(sp) == 2'd0 && $past(ix) < NW_IX
     && $stable(bus_addr)) |-> (bus_rdata == $past(bus_wdata)));

  // R4
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != 2'd3 && ix >= NW_IX) |-> (bus_rdata == 32'd0));
endmodule

bind eint_ctrl eint_ctrl_chk #(.NGRP(NGRP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/tb_eint_ctrl.sv
module tb_eint_ctrl;
  localparam int NGRP  = 9;
  localparam int GL    = 16;
  localparam int AW    = 6;
  localparam int NLINE = NGRP * GL;
  localparam int NWORD = (NGRP + 1) / 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NLINE-1:0]  ext_in;
  logic              bus_we;
  logic [AW-1:0]     bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eint_ctrl #(.NGRP(NGRP), .GL(GL), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit          m_s1 [NLINE];
  bit          m_s2 [NLINE];
  bit          m_s3 [NLINE];
  logic [31:0] m_cfg  [NWORD];
  logic [31:0] m_mask [NWORD];
  logic [31:0] m_pend [NWORD];
  logic [31:0] np     [NWORD];

  function automatic bit fires(int sel, bit cur, bit old);
    if (sel == 0) return !cur;
    if (sel == 1) return cur;
    if (sel == 2) return old && !cur;
    if (sel == 4) return !old && cur;
    if (sel == 6) return old != cur;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORD; w++) begin
        m_cfg[w] = 32'h4444_4444; m_mask[w] = 32'hFFFF_FFFF; m_pend[w] = 32'h0;
      end
      for (int l = 0; l < NLINE; l++) begin
        m_s1[l] = 0; m_s2[l] = 0; m_s3[l] = 0;
      end
    end else begin
      for (int w = 0; w < NWORD; w++) begin
        np[w] = m_pend[w];
        if (bus_we && bus_addr[5:4] == 2'd2 && int'(bus_addr[3:0]) == w)
          np[w] = np[w] & ~bus_wdata;
      end
      for (int g = 0; g < NGRP; g++) begin
        for (int p = 0; p < GL; p++) begin
          int w, b, sel;
          w = g / 2; b = (g % 2) * 16 + p;
          sel = int'((m_cfg[w] >> (4 * (b / 4))) & 32'hF);
          if (fires(sel, m_s2[g*GL+p], m_s3[g*GL+p])) np[w][b] = 1'b1;
        end
      end
      for (int w = 0; w < NWORD; w++) begin
        if (bus_we && int'(bus_addr[3:0]) == w) begin
          if (bus_addr[5:4] == 2'd0) m_cfg[w]  = bus_wdata;
          if (bus_addr[5:4] == 2'd1) m_mask[w] = bus_wdata;
        end
        m_pend[w] = np[w];
      end
      for (int l = 0; l < NLINE; l++) begin
        m_s3[l] = m_s2[l]; m_s2[l] = m_s1[l]; m_s1[l] = ext_in[l];
      end
    end
  end

  function automatic logic [31:0] exp_svc();
    for (int g = 0; g < NGRP; g++)
      for (int p = 0; p < GL; p++) begin
        int w, b;
        w = g / 2; b = (g % 2) * 16 + p;
        if (m_pend[w][b] && !m_mask[w][b]) return 32'((g + 1) * 16 + p);
      end
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    int w;
    w = int'(a[3:0]);
    if (a[5:4] == 2'd3) return exp_svc();
    if (w >= NWORD) return 32'h0;
    if (a[5:4] == 2'd0) return m_cfg[w];
    if (a[5:4] == 2'd1) return m_mask[w];
    return m_pend[w];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, a quarter period after the edge.
  always @(posedge clk) begin
    #5;
    if (rst_n === 1'b1 && !done) begin
      case (bus_addr[5:4])
        2'd2:    chk("R6 model pending", bus_rdata, exp_rd(bus_addr));
        2'd3:    chk("R8 model service", bus_rdata, exp_rd(bus_addr));
        default: chk("R11 model word", bus_rdata, exp_rd(bus_addr));
      endcase
      chk("R9 model irq", {31'b0, irq}, {31'b0, exp_svc() != 0});
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [AW-1:0] ad(int space, int w);
    return AW'(space * 16 + w);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] exp);
    bus_addr = a;
    #2;
    chk(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(string req, logic exp);
    #2;
    chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tick(3);
    rst_n = 1'b1;

    // R10 reset state
    rd_chk("R10 cfg reset", ad(0, 0), 32'h4444_4444);
    rd_chk("R10 mask reset", ad(1, 4), 32'hFFFF_FFFF);
    rd_chk("R10 pending reset", ad(2, 0), 32'h0);
    rd_chk("R10 service reset", ad(3, 0), 32'h0);
    irq_chk("R10 irq reset", 1'b0);

    // R1 latency, rising edge, service and irq
    wr(ad(1, 0), 32'h0);
    tick(1);
    ext_in[3] = 1'b1;
    tick(2);
    rd_chk("R1 not before edge k+2", ad(2, 0), 32'h0);
    tick(1);
    rd_chk("R1 set at edge k+2", ad(2, 0), 32'h8);
    rd_chk("R8 group1 pin3", ad(3, 0), 32'h13);
    irq_chk("R9 irq high", 1'b1);

    // R6 write one to clear, zeros ignored
    wr(ad(2, 0), 32'h0);
    rd_chk("R6 zero write keeps", ad(2, 0), 32'h8);
    wr(ad(2, 0), 32'h8);
    rd_chk("R6 one write clears", ad(2, 0), 32'h0);
    irq_chk("R9 irq low", 1'b0);

    // R7 high level holds pending over a clear
    wr(ad(0, 0), 32'h4444_4441);
    tick(1);
    rd_chk("R7 level sets", ad(2, 0), 32'h8);
    wr(ad(2, 0), 32'h8);
    rd_chk("R7 level survives clear", ad(2, 0), 32'h8);
    wr(ad(0, 0), 32'h4444_4444);
    wr(ad(2, 0), 32'h8);
    rd_chk("R7 clear after edge mode", ad(2, 0), 32'h0);

    // R3 lines 4-7 share a falling selector
    wr(ad(0, 0), 32'h4444_4424);
    ext_in[5] = 1'b1; ext_in[6] = 1'b1;
    tick(4);
    rd_chk("R3 rising ignored under falling", ad(2, 0), 32'h0);
    ext_in[5] = 1'b0; ext_in[6] = 1'b0;
    tick(4);
    rd_chk("R3 shared falling selector", ad(2, 0), 32'h60);
    wr(ad(2, 0), 32'h60);

    // R2 unsupported code 3 never fires
    wr(ad(0, 0), 32'h4444_4423);
    ext_in[2] = 1'b1;
    tick(4);
    rd_chk("R2 code 3 no rise", ad(2, 0), 32'h0);
    ext_in[2] = 1'b0;
    tick(4);
    rd_chk("R2 code 3 no fall", ad(2, 0), 32'h0);
    wr(ad(0, 0), 32'h4444_4444);

    // R2 low level on group 3, masked (R5)
    wr(ad(0, 1), 32'h4444_4440);
    tick(1);
    rd_chk("R2 low level", ad(2, 1), 32'hF);
    irq_chk("R5 masked no irq", 1'b0);
    rd_chk("R5 masked no service", ad(3, 0), 32'h0);
    wr(ad(0, 1), 32'h4444_4444);
    wr(ad(2, 1), 32'hF);
    rd_chk("R6 clear low-level bits", ad(2, 1), 32'h0);

    // R4 group 4 pin 2 at word 1 bit 18; R5 unmask; R8 priority
    ext_in[3*16+2] = 1'b1;
    tick(4);
    rd_chk("R4 group4 placement", ad(2, 1), 32'h0004_0000);
    irq_chk("R5 masked line", 1'b0);
    wr(ad(1, 1), 32'hFFFB_FFFF);
    irq_chk("R5 unmasked line", 1'b1);
    rd_chk("R8 group4 pin2", ad(3, 0), 32'h42);
    ext_in[16+9] = 1'b1;
    tick(4);
    rd_chk("R8 lower group wins", ad(3, 0), 32'h29);
    ext_in[16+1] = 1'b1;
    tick(4);
    rd_chk("R8 lower pin wins", ad(3, 0), 32'h21);
    wr(ad(2, 0), 32'hFFFF_FFFF);
    rd_chk("R8 falls back", ad(3, 0), 32'h42);

    // R4 last group, unused half, holes; R11 service write ignored
    wr(ad(1, 4), 32'h0);
    ext_in[8*16+15] = 1'b1;
    tick(4);
    rd_chk("R4 group9 pin15", ad(2, 4), 32'h0000_8000);
    wr(ad(2, 1), 32'hFFFF_FFFF);
    rd_chk("R8 group9 code", ad(3, 0), 32'h9F);
    wr(ad(1, 7), 32'h1234_5678);
    rd_chk("R4 hole reads zero", ad(1, 7), 32'h0);
    rd_chk("R4 word5 reads zero", ad(0, 5), 32'h0);
    wr(ad(3, 0), 32'hFFFF_FFFF);
    rd_chk("R11 service write ignored", ad(3, 0), 32'h9F);
    rd_chk("R11 mask readback", ad(1, 1), 32'hFFFB_FFFF);

    // R2 both edges on group 9 pin 15
    wr(ad(0, 4), 32'h4444_6444);
    wr(ad(2, 4), 32'h0000_8000);
    rd_chk("R6 group9 cleared", ad(2, 4), 32'h0);
    ext_in[8*16+15] = 1'b0;
    tick(4);
    rd_chk("R2 both edges falling", ad(2, 4), 32'h0000_8000);
    wr(ad(2, 4), 32'h0000_8000);
    ext_in[8*16+15] = 1'b1;
    tick(4);
    rd_chk("R2 both edges rising", ad(2, 4), 32'h0000_8000);
    wr(ad(2, 4), 32'h0000_8000);
    irq_chk("R9 all clear", 1'b0);
    tick(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule